// File: doc/BRIEF.md
# Oscillator Tuning Word Serial Receiver

This block takes a tuning command for a voltage-controlled crystal oscillator from a three-wire serial port and presents it as an 8-bit code for the tuning DAC. The serial port has a bit clock, a data line and a strobe line. Each transfer is a 16-bit frame, most significant bit first. Only the leading byte of the frame carries the command, and the trailing byte is discarded. When the strobe falls after a complete frame, the command moves into the output register and a one-cycle valid pulse is raised.

The command is a signed two's-complement number. The DAC wants an unsigned offset-binary code, so the block flips the command's top bit. The most negative command then gives the lowest DAC code and a zero command gives mid-scale. The serial pins are asynchronous to the system clock. They pass through two-flop synchronisers, and their edges are found in the system clock domain. A strobe that falls after any bit count other than 16 changes nothing at the output and raises a one-cycle frame-error flag instead.

A frame state machine tracks progress through the frame. Its states are:
- `ST_IDLE`: no bits yet.
- `ST_CMD`: taking the command byte.
- `ST_PAD`: skipping the tail.
- `ST_FULL`: exactly 16 bits received.
- `ST_OVER`: more than 16 bits received.

Its transitions are:
- A bit clock rise moves `ST_IDLE` to `ST_CMD`.
- The 8th bit moves `ST_CMD` to `ST_PAD`.
- The 16th bit moves `ST_PAD` to `ST_FULL`.
- A 17th bit moves `ST_FULL` to `ST_OVER`, and `ST_OVER` stays there on further bits.
- A strobe fall returns every state to `ST_IDLE`. From `ST_FULL` this commits the command; from any other state it reports an error.

Top module: `vcxo_tune_rx`

## Requirements
- R1: After reset, `dac_code` is 0x80, `dac_valid` is 0 and `frame_err` is 0.
- R2: Bits are taken from `ser_dat` on rising edges of `ser_clk`, and the first bit received is the command's most significant bit.
- R3: Only the first 8 bits of a frame form the command. The value of bits 9 to 16 has no effect on `dac_code`.
- R4: `dac_code` is the command with bit 7 inverted. Command 0x80 gives 0x00, 0x00 gives 0x80 and 0x7F gives 0xFF.
- R5: A falling edge of `ser_le` after exactly 16 bit-clock rises loads the new code and pulses `dac_valid` high for one cycle.
- R6: `dac_code`, `dac_valid` and `frame_err` respond on the fourth rising edge of `clk` counted from the first edge that sees the `ser_le` fall.
- R7: A falling edge of `ser_le` after fewer than 16 bits leaves `dac_code` unchanged, gives no `dac_valid` and pulses `frame_err` for one cycle.
- R8: A falling edge of `ser_le` after more than 16 bits behaves as in R7.
- R9: Every falling edge of `ser_le` restarts the bit count, so the next frame decodes from its first bit.
- R10: A rising edge of `ser_le`, and `ser_le` held high, has no effect on `dac_code`, `dac_valid` or `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data taken on its rise |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; its fall ends a frame |
| dac_code | output | 8 | Offset-binary code for the tuning DAC |
| dac_valid | output | 1 | One-cycle pulse when `dac_code` is loaded |
| frame_err | output | 1 | One-cycle pulse on a frame of the wrong length |

## Verification
A pin change first seen at clock edge k has three registers on its way to an output: the second synchroniser flop, the frame state machine register and the output register. The result therefore shows after edge k+3. The bench's behavioural model pushes each result it computes through a three-slot delay queue and compares its output with the ports on every falling clock edge, away from the active edge. A directed check counts the edges after a strobe fall to confirm that `dac_valid` stays low for three edges and rises on the fourth. Code and pulse-count checks are made only after a frame has had time to settle.

// File: rtl/vctune_pkg.sv
package vctune_pkg;

    // Progress through one serial frame
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_PAD  = 3'd2,
        ST_FULL = 3'd3,
        ST_OVER = 3'd4
    } rx_state_t;

endpackage

// File: rtl/vt_pin_sync.sv
module vt_pin_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    generate
        for (genvar p = 0; p < W; p++) begin : g_pin
            // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
            logic [STAGES:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-1:0], pin_i[p]};
                end
            end

            assign lvl_o[p]  = chain[STAGES-1];
            assign rise_o[p] = chain[STAGES-1] & ~chain[STAGES];
            assign fall_o[p] = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/vt_frame_fsm.sv
module vt_frame_fsm
    import vctune_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int CMD_W     = 8,
    parameter int CNT_W     = $clog2(FRAME_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_rise_i,
    input  logic             bit_dat_i,
    input  logic             strobe_fall_i,
    output logic             commit_o,
    output logic             error_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(FRAME_LEN + 1);

    rx_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] cmd;
    logic             take_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state; the strobe fall wins over a bit in the same cycle
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (strobe_fall_i)   nxt = ST_IDLE;
                else if (bit_rise_i) nxt = ST_CMD;
            end
            ST_CMD: begin
                if (strobe_fall_i)                       nxt = ST_IDLE;
                else if (bit_rise_i && cnt == CMD_LAST)  nxt = ST_PAD;
            end
            ST_PAD: begin
                if (strobe_fall_i)                        nxt = ST_IDLE;
                else if (bit_rise_i && cnt == FRAME_LAST) nxt = ST_FULL;
            end
            ST_FULL: begin
                if (strobe_fall_i)   nxt = ST_IDLE;
                else if (bit_rise_i) nxt = ST_OVER;
            end
            ST_OVER: begin
                if (strobe_fall_i)   nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Bit counter and command shifter
    assign take_bit = bit_rise_i && !strobe_fall_i &&
                      (state == ST_IDLE || state == ST_CMD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            cmd <= '0;
        end else begin
            if (strobe_fall_i) begin
                cnt <= '0;
            end else if (bit_rise_i && cnt != CNT_SAT) begin
                cnt <= cnt + 1'b1;
            end
            if (take_bit) begin
                cmd <= {cmd[CMD_W-2:0], bit_dat_i};
            end
        end
    end

    // Registered frame outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_o <= 1'b0;
            error_o  <= 1'b0;
        end else begin
            commit_o <= strobe_fall_i && (state == ST_FULL);
            error_o  <= strobe_fall_i && (state != ST_FULL);
        end
    end

    assign cmd_o = cmd;
    assign cnt_o = cnt;

endmodule

// File: rtl/vt_code_map.sv
module vt_code_map #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic             error_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic [CMD_W-1:0] code_o,
    output logic             valid_o,
    output logic             err_o
);

    localparam logic [CMD_W-1:0] MID_CODE = {1'b1, {(CMD_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o  <= MID_CODE;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= commit_i;
            err_o   <= error_i;
            if (commit_i) begin
                // two's complement to offset binary
                code_o <= cmd_i ^ MID_CODE;
            end
        end
    end

endmodule

// File: rtl/vcxo_tune_rx.sv
module vcxo_tune_rx #(
    parameter int FRAME_LEN   = 16,
    parameter int CMD_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    output logic [CMD_W-1:0] dac_code,
    output logic             dac_valid,
    output logic             frame_err
);

    localparam int CNT_W = $clog2(FRAME_LEN + 2);
    localparam int P_CLK = 0;
    localparam int P_DAT = 1;
    localparam int P_LE  = 2;

    logic [2:0]       pins, lvl, rise, fall;
    logic             fsm_commit, fsm_error;
    logic [CMD_W-1:0] fsm_cmd;
    logic [CNT_W-1:0] fsm_cnt;
    logic             sync_unused;

    assign pins = {ser_le, ser_dat, ser_clk};

    vt_pin_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign sync_unused = ^{lvl[P_CLK], lvl[P_LE], rise[P_DAT], rise[P_LE],
                           fall[P_CLK], fall[P_DAT]};

    vt_frame_fsm #(.FRAME_LEN(FRAME_LEN), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_rise_i    (rise[P_CLK]),
        .bit_dat_i     (lvl[P_DAT]),
        .strobe_fall_i (fall[P_LE]),
        .commit_o      (fsm_commit),
        .error_o       (fsm_error),
        .cmd_o         (fsm_cmd),
        .cnt_o         (fsm_cnt)
    );

    vt_code_map #(.CMD_W(CMD_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (fsm_commit),
        .error_i  (fsm_error),
        .cmd_i    (fsm_cmd),
        .code_o   (dac_code),
        .valid_o  (dac_valid),
        .err_o    (frame_err)
    );

endmodule

// File: rtl/vt_tune_chk.sv
module vt_tune_chk #(
    parameter int FRAME_LEN = 16,
    parameter int CMD_W     = 8,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CMD_W-1:0] dac_code,
    input logic             dac_valid,
    input logic             frame_err,
    input logic [CMD_W-1:0] cmd_q,
    input logic [CNT_W-1:0] bit_cnt
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid); // R5

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R7

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_valid && frame_err)); // R8

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> $stable(dac_code)); // R3

    AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> dac_code == $past(dac_code)); // R7

    AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(bit_cnt, 2) == CNT_W'(FRAME_LEN)); // R5

    AST_MSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> (dac_code[CMD_W-1] != $past(cmd_q[CMD_W-1]) &&
                       dac_code[CMD_W-2:0] == $past(cmd_q[CMD_W-2:0]))); // R4

endmodule

bind vcxo_tune_rx vt_tune_chk #(.FRAME_LEN(FRAME_LEN), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dac_code  (dac_code),
    .dac_valid (dac_valid),
    .frame_err (frame_err),
    .cmd_q     (fsm_cmd),
    .bit_cnt   (fsm_cnt)
);

// File: tb/test_vcxo_tune_rx.sv
`timescale 1ns/1ps
module test_vcxo_tune_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_le = 1'b0;
    logic [7:0] dac_code;
    logic       dac_valid;
    logic       frame_err;

    int checks = 0;
    int fails = 0;
    int n_valid = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vcxo_tune_rx i_vcxo_tune_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_le    (ser_le),
        .dac_code  (dac_code),
        .dac_valid (dac_valid),
        .frame_err (frame_err)
    );

    // Behavioural reference: pin samples per edge, results delayed three edges
    bit         m_prev_clk, m_prev_le;
    int         m_bits;
    logic [7:0] m_cmd;
    bit         q_val[$];
    bit         q_err[$];
    logic [7:0] q_code[$];
    bit         e_val = 1'b0;
    bit         e_err = 1'b0;
    logic [7:0] e_code = 8'h80;

    always @(posedge clk) begin
        bit         ev_val, ev_err;
        logic [7:0] ev_code;
        if (!rst_n) begin
            m_prev_clk = 1'b0; m_prev_le = 1'b0; m_bits = 0; m_cmd = 8'h00;
            q_val = {1'b0, 1'b0, 1'b0};
            q_err = {1'b0, 1'b0, 1'b0};
            q_code = {8'h80, 8'h80, 8'h80};
            e_val = 1'b0; e_err = 1'b0; e_code = 8'h80;
        end else begin
            ev_val = 1'b0; ev_err = 1'b0; ev_code = q_code[$];
            if (m_prev_le && !ser_le) begin
                if (m_bits == 16) begin
                    ev_val = 1'b1;
                    ev_code = {~m_cmd[7], m_cmd[6:0]};
                end else begin
                    ev_err = 1'b1;
                end
                m_bits = 0;
            end else if (!m_prev_clk && ser_clk) begin
                if (m_bits < 8) m_cmd = {m_cmd[6:0], ser_dat};
                if (m_bits < 17) m_bits++;
            end
            m_prev_clk = ser_clk;
            m_prev_le = ser_le;
            q_val.push_back(ev_val);
            q_err.push_back(ev_err);
            q_code.push_back(ev_code);
            e_val = q_val.pop_front();
            e_err = q_err.pop_front();
            e_code = q_code.pop_front();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(dac_code === e_code, "R4 model code", int'(dac_code), int'(e_code));
            check(dac_valid === e_val, "R5 model valid", int'(dac_valid), int'(e_val));
            check(frame_err === e_err, "R7 model err", int'(frame_err), int'(e_err));
            if (dac_valid) n_valid++;
            if (frame_err) n_err++;
        end
    end

    task automatic send_bits(input logic [31:0] word, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_dat = word[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic strobe();
        @(negedge clk); ser_le = 1'b1;
        repeat (3) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame_check(input logic [31:0] word, input int n,
                               input logic [7:0] exp_code, input bit good, input string req);
        int v0, e0;
        v0 = n_valid; e0 = n_err;
        send_bits(word, n);
        strobe();
        check(dac_code === exp_code, req, int'(dac_code), int'(exp_code));
        check(n_valid == v0 + (good ? 1 : 0), {req, " valid count"}, n_valid - v0, good ? 1 : 0);
        check(n_err == e0 + (good ? 0 : 1), {req, " error count"}, n_err - e0, good ? 0 : 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dac_code === 8'h80, "R1 reset code", int'(dac_code), 8'h80);
        check(dac_valid === 1'b0, "R1 reset valid", int'(dac_valid), 0);
        check(frame_err === 1'b0, "R1 reset err", int'(frame_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        frame_check(32'h80AA, 16, 8'h00, 1'b1, "R4 most negative");
        frame_check(32'h7F00, 16, 8'hFF, 1'b1, "R4 most positive");
        frame_check(32'h0055, 16, 8'h80, 1'b1, "R4 zero");
        frame_check(32'hA100, 16, 8'h21, 1'b1, "R2 msb first");
        frame_check(32'h35FF, 16, 8'hB5, 1'b1, "R3 tail ones");
        frame_check(32'h3500, 16, 8'hB5, 1'b1, "R3 tail zeros");
        frame_check(32'h0FFF, 12, 8'hB5, 1'b0, "R7 short frame");
        frame_check(32'h1FFFF, 17, 8'hB5, 1'b0, "R8 long frame");
        frame_check(32'h0000, 0, 8'hB5, 1'b0, "R7 empty frame");
        frame_check(32'h4C12, 16, 8'hCC, 1'b1, "R9 after errors");

        // R10: strobe raised and held, then R6 latency on its fall
        begin
            int v0;
            v0 = n_valid;
            send_bits(32'hE700, 16);
            @(negedge clk); ser_le = 1'b1;
            repeat (20) @(negedge clk);
            check(n_valid == v0 && !frame_err, "R10 strobe high", n_valid - v0, 0);
            check(dac_code === 8'hCC, "R10 code held", int'(dac_code), 8'hCC);
            ser_le = 1'b0;
            for (int k = 1; k <= 3; k++) begin
                @(posedge clk); #1;
                check(dac_valid === 1'b0, "R6 early edge", int'(dac_valid), 0);
            end
            @(posedge clk); #1;
            check(dac_valid === 1'b1, "R6 fourth edge", int'(dac_valid), 1);
            check(dac_code === 8'h67, "R5 loaded code", int'(dac_code), 8'h67);
            repeat (6) @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule